// File: doc/BRIEF.md
# Predicate Register File with Compare

This block holds the 1-bit predicate state for a wide-issue core that runs predicated code. It has a compare unit that tests two 64-bit operands under one of four conditions. The compare writes the outcome into one destination predicate and the inverted outcome into a second destination predicate, at the same clock edge. Code from both arms of an if/else can then be guarded by the two halves of the pair and issued side by side.

Every issue slot of a bundle names a qualifying predicate. The block returns one write-enable per slot. That enable is high only when the slot is valid and its qualifying predicate is true, so a slot with a false qualifier turns into a no-op. The compare has its own qualifying predicate. Predicate 0 always reads as true and serves as the unconditional guard.

Predicate writes take effect at the clock edge. Parameter `BYPASS` selects what the slot enables see in the cycle of a compare. With `BYPASS` set, they see the value being written in that cycle. With it clear, they see the stored value.

Top module: `pred_unit`

## Requirements
- R1: After reset, `pred_o` equals 64'h1: every predicate is false except predicate 0.
- R2: Predicate 0 reads as 1 at all times. A compare whose destination index is 0 leaves it unchanged and still updates its other destination.
- R3: `cmp_cond_i` code 0 tests a == b and code 1 tests a != b.
- R4: `cmp_cond_i` code 2 tests a < b with both operands as signed two's complement. Code 3 tests a < b with both operands unsigned.
- R5: A compare that fires writes the condition result into predicate `cmp_pt_i` and its complement into predicate `cmp_pf_i`. Both values are visible on `pred_o` one clock edge later.
- R6: A compare fires only when `cmp_valid_i` is high and the predicate indexed by `cmp_qp_i` is 1. Otherwise no predicate changes.
- R7: When `cmp_pt_i` equals `cmp_pf_i` and is nonzero, that predicate takes the condition result, not its complement.
- R8: `slot_we_o[i]` equals `slot_valid_i[i]` AND the qualifying predicate selected by `slot_qp_i[i*6 +: 6]`. Each slot is decided independently of the others.
- R9: With `BYPASS`=0, a slot whose qualifier is being written by a compare in the same cycle uses the old value. With `BYPASS`=1 it uses the value being written.
- R10: After a compare, two valid slots guarded by `cmp_pt_i` and `cmp_pf_i` of that compare (both distinct and nonzero) give exactly one enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_valid_i | input | 1 | Compare request |
| cmp_qp_i | input | 6 | Qualifying predicate of the compare |
| cmp_cond_i | input | 2 | Condition code: 0 eq, 1 ne, 2 signed lt, 3 unsigned lt |
| cmp_a_i | input | 64 | First operand |
| cmp_b_i | input | 64 | Second operand |
| cmp_pt_i | input | 6 | Destination that receives the result |
| cmp_pf_i | input | 6 | Destination that receives the complement |
| slot_valid_i | input | 3 | Per-slot valid |
| slot_qp_i | input | 18 | Per-slot qualifying predicate, 6 bits per slot, slot 0 in the low bits |
| slot_we_o | output | 3 | Per-slot writeback and side-effect enable |
| pred_o | output | 64 | Current predicate state, bit n is predicate n |

## Verification
The assertions check several things on every cycle. A fired compare must land its result and complement in the named predicates on the next cycle. Predicate state must not move when no compare fires, including when the compare's own qualifier is false. With no bypass, a slot enable must never be high unless the slot is valid and its stored qualifier is true. Other behaviour shows up only in the bench scenarios: the exact comparison semantics (signed versus unsigned at the sign boundary), the fixed true value of predicate 0, the winner when both destinations coincide, the bypass difference between two instances, and the complementary slot enables after an if/else compare.

// File: rtl/pred_pkg.sv
package pred_pkg;
  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_NE  = 2'd1,
    CMP_LT  = 2'd2,
    CMP_LTU = 2'd3
  } cmp_cond_e;
endpackage

// File: rtl/pred_compare.sv
module pred_compare #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [1:0]        cond_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              res_o
);
  import pred_pkg::*;

  logic eq, lts, ltu;
  assign eq  = (a_i == b_i);
  assign lts = ($signed(a_i) < $signed(b_i));
  assign ltu = (a_i < b_i);

  always_comb begin
    unique case (cmp_cond_e'(cond_i))
      CMP_EQ:  res_o = eq;   // R3
      CMP_NE:  res_o = !eq;  // R3
      CMP_LT:  res_o = lts;  // R4
      CMP_LTU: res_o = ltu;  // R4
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_regfile.sv
module pred_regfile #(
  parameter int unsigned NPRED  = 64,
  localparam int unsigned PIDX_W = $clog2(NPRED)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PIDX_W-1:0] t_idx_i,
  input  logic [PIDX_W-1:0] f_idx_i,
  input  logic              val_i,
  output logic [NPRED-1:0]  state_o
);
  for (genvar k = 0; k < NPRED; k++) begin : g_pred
    if (k == 0) begin : g_hard
      assign state_o[k] = 1'b1;  // R2: unconditional guard
    end else begin : g_flop
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                q <= 1'b0;
        else if (we_i && t_idx_i == PIDX_W'(k))     q <= val_i;   // R7: true dest wins
        else if (we_i && f_idx_i == PIDX_W'(k))     q <= !val_i;
      end
      assign state_o[k] = q;
    end
  end

  p_wr_true_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && t_idx_i != '0) |=> state_o[$past(t_idx_i)] == $past(val_i));

  p_wr_false_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && f_idx_i != '0 && f_idx_i != t_idx_i) |=> state_o[$past(f_idx_i)] == !$past(val_i));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(state_o));
endmodule

// File: rtl/slot_nullify.sv
module slot_nullify #(
  parameter int unsigned NPRED  = 64,
  parameter int unsigned NSLOT  = 3,
  parameter bit          BYPASS = 1'b0,
  localparam int unsigned PIDX_W = $clog2(NPRED)
) (
  input  logic [NPRED-1:0]        state_i,
  input  logic [NSLOT-1:0]        valid_i,
  input  logic [NSLOT*PIDX_W-1:0] qp_i,
  input  logic                    pend_we_i,
  input  logic [PIDX_W-1:0]       pend_t_i,
  input  logic [PIDX_W-1:0]       pend_f_i,
  input  logic                    pend_val_i,
  output logic [NSLOT-1:0]        we_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [PIDX_W-1:0] qp;
    logic stored, fwd, qual;
    assign qp     = qp_i[s*PIDX_W +: PIDX_W];
    assign stored = state_i[qp];
    always_comb begin
      fwd = stored;
      if (pend_we_i && qp != '0) begin
        if (qp == pend_t_i)      fwd = pend_val_i;
        else if (qp == pend_f_i) fwd = !pend_val_i;
      end
    end
    assign qual    = BYPASS ? fwd : stored;  // R9
    assign we_o[s] = valid_i[s] && qual;     // R8
  end
endmodule

// File: rtl/pred_unit.sv
module pred_unit #(
  parameter int unsigned NPRED  = 64,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NSLOT  = 3,
  parameter bit          BYPASS = 1'b0,
  localparam int unsigned PIDX_W = $clog2(NPRED)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmp_valid_i,
  input  logic [PIDX_W-1:0]       cmp_qp_i,
  input  logic [1:0]              cmp_cond_i,
  input  logic [DATA_W-1:0]       cmp_a_i,
  input  logic [DATA_W-1:0]       cmp_b_i,
  input  logic [PIDX_W-1:0]       cmp_pt_i,
  input  logic [PIDX_W-1:0]       cmp_pf_i,
  input  logic [NSLOT-1:0]        slot_valid_i,
  input  logic [NSLOT*PIDX_W-1:0] slot_qp_i,
  output logic [NSLOT-1:0]        slot_we_o,
  output logic [NPRED-1:0]        pred_o
);
  logic [NPRED-1:0] state;
  logic cmp_res, cmp_fire;

  assign cmp_fire = cmp_valid_i && state[cmp_qp_i];  // R6

  pred_compare #(.DATA_W(DATA_W)) u_cmp (
    .cond_i(cmp_cond_i), .a_i(cmp_a_i), .b_i(cmp_b_i), .res_o(cmp_res)
  );

  pred_regfile #(.NPRED(NPRED)) u_rf (
    .clk_i, .rst_ni, .we_i(cmp_fire), .t_idx_i(cmp_pt_i), .f_idx_i(cmp_pf_i),
    .val_i(cmp_res), .state_o(state)
  );

  slot_nullify #(.NPRED(NPRED), .NSLOT(NSLOT), .BYPASS(BYPASS)) u_null (
    .state_i(state), .valid_i(slot_valid_i), .qp_i(slot_qp_i),
    .pend_we_i(cmp_fire), .pend_t_i(cmp_pt_i), .pend_f_i(cmp_pf_i),
    .pend_val_i(cmp_res), .we_o(slot_we_o)
  );

  assign pred_o = state;

  p_qual_false_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_valid_i || !pred_o[cmp_qp_i]) |=> $stable(pred_o));

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    if (!BYPASS) begin : g_nobyp
      p_slot_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_we_o[s] |-> (slot_valid_i[s] && pred_o[slot_qp_i[s*PIDX_W +: PIDX_W]]));
    end
  end
endmodule

// File: tb/pred_unit_tb.sv
module pred_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [5:0]  cmp_qp = '0, cmp_pt = '0, cmp_pf = '0;
  logic [1:0]  cmp_cond = '0;
  logic [63:0] cmp_a = '0, cmp_b = '0;
  logic [2:0]  slot_valid = '0;
  logic [17:0] slot_qp = '0;
  logic [2:0]  we_d, we_b;
  logic [63:0] pred_d, pred_b;
  logic [63:0] m = 64'h1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pred_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_valid_i(cmp_valid), .cmp_qp_i(cmp_qp),
    .cmp_cond_i(cmp_cond), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cmp_pt_i(cmp_pt),
    .cmp_pf_i(cmp_pf), .slot_valid_i(slot_valid), .slot_qp_i(slot_qp),
    .slot_we_o(we_d), .pred_o(pred_d)
  );

  pred_unit #(.BYPASS(1'b1)) u_byp (
    .clk_i(clk), .rst_ni(rst_n), .cmp_valid_i(cmp_valid), .cmp_qp_i(cmp_qp),
    .cmp_cond_i(cmp_cond), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cmp_pt_i(cmp_pt),
    .cmp_pf_i(cmp_pf), .slot_valid_i(slot_valid), .slot_qp_i(slot_qp),
    .slot_we_o(we_b), .pred_o(pred_b)
  );

  function automatic logic eval(logic [1:0] c, logic [63:0] a, logic [63:0] b);
    case (c)
      2'd0:    return a == b;
      2'd1:    return a != b;
      2'd2:    return $signed(a) < $signed(b);
      default: return a < b;
    endcase
  endfunction

  function automatic logic [63:0] next_state(logic [63:0] s);
    logic [63:0] n = s;
    logic r = eval(cmp_cond, cmp_a, cmp_b);
    if (cmp_valid && s[cmp_qp]) begin
      n[cmp_pf] = !r;
      n[cmp_pt] = r;  // R7: true destination written last
    end
    n[0] = 1'b1;
    return n;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs already driven after a negedge; checks enables, clocks, checks state.
  task automatic step(string req);
    logic [63:0] nx;
    logic [2:0] e_d, e_b;
    #1;
    nx = next_state(m);
    for (int s = 0; s < 3; s++) begin
      e_d[s] = slot_valid[s] & m[slot_qp[s*6 +: 6]];
      e_b[s] = slot_valid[s] & nx[slot_qp[s*6 +: 6]];
    end
    chk({req, "/R8 we"}, 64'(we_d), 64'(e_d));
    chk({req, "/R9 we bypass"}, 64'(we_b), 64'(e_b));
    @(posedge clk);
    m = nx;
    @(negedge clk);
    chk({req, " state"}, pred_d, m);
    chk({req, " state bypass"}, pred_b, m);
  endtask

  task automatic cmp(logic v, logic [5:0] qp, logic [1:0] c, logic [63:0] a,
                     logic [63:0] b, logic [5:0] pt, logic [5:0] pf);
    cmp_valid = v; cmp_qp = qp; cmp_cond = c; cmp_a = a; cmp_b = b;
    cmp_pt = pt; cmp_pf = pf;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 reset", pred_d, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 eq true -> p1=1, p2=0
    cmp(1, 0, 2'd0, 64'd5, 64'd5, 6'd1, 6'd2); step("R3 eq");
    // R3 ne on equal operands -> p3=0, p4=1
    cmp(1, 0, 2'd1, 64'd7, 64'd7, 6'd3, 6'd4); step("R3 ne");
    // R4 signed: -1 < 1 true -> p5=1
    cmp(1, 0, 2'd2, '1, 64'd1, 6'd5, 6'd6); step("R4 lt");
    // R4 unsigned: all-ones < 1 false -> p7=0, p8=1
    cmp(1, 0, 2'd3, '1, 64'd1, 6'd7, 6'd8); step("R4 ltu");
    // R2 p0 as true dest, result false: p0 stays 1, p9=1
    cmp(1, 0, 2'd0, 64'd1, 64'd2, 6'd0, 6'd9); step("R2 p0 write");
    chk("R2 p0", 64'(pred_d[0]), 64'd1);
    // R7 same dest, result true
    cmp(1, 0, 2'd0, 64'd3, 64'd3, 6'd10, 6'd10); step("R7 same dest");
    chk("R7 p10", 64'(pred_d[10]), 64'd1);
    // R6 qualifier false (p2=0): nothing changes
    cmp(1, 6'd2, 2'd0, 64'd3, 64'd3, 6'd11, 6'd12); step("R6 qp false");
    // R6 valid low
    cmp(0, 0, 2'd0, 64'd3, 64'd3, 6'd13, 6'd14); step("R6 invalid");
    // R9 bypass: write p12=1 while slot 0 reads p12 (old 0)
    cmp(1, 0, 2'd0, 64'd4, 64'd4, 6'd12, 6'd13);
    slot_valid = 3'b001; slot_qp = 18'd12; step("R9 bypass");
    // R10 if/else: p20 / p21 then slots guarded by each
    cmp(1, 0, 2'd2, 64'd9, 64'd3, 6'd20, 6'd21); slot_valid = '0; step("R10 setup");
    cmp(0, 0, 0, 0, 0, 0, 0);
    slot_valid = 3'b011; slot_qp = {6'd0, 6'd21, 6'd20};
    step("R10 pair");
    chk("R10 one enable", 64'($countones(we_d[1:0])), 64'd1);

    // R5 R8 random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : 64'($signed($urandom_range(0, 6)) - 3);
      b = ($urandom_range(0, 3) == 0) ? a : 64'($signed($urandom_range(0, 6)) - 3);
      cmp($urandom_range(0, 3) != 0, 6'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
          a, b, 6'($urandom_range(0, 9)), 6'($urandom_range(0, 9)));
      slot_valid = 3'($urandom);
      slot_qp = {6'($urandom_range(0, 9)), 6'($urandom_range(0, 9)), 6'($urandom_range(0, 9))};
      step("R5 random");
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule